// File: doc/BRIEF.md
# Multi-Lane Sample Word Checker

This block sits at the receive end of a multi-lane link test path. Every valid cycle it gets one 64-bit sample word per lane, together with a valid strobe and a start-of-burst marker. Each word carries three fields. A lane tag sits in bits 63..59. A burst counter sits in bits 58..32. A running word counter sits in bits 31..0. The checker confirms that each word arrived on the lane its tag names. It also confirms that the word counter keeps climbing, and that the burst counter moves only at a burst start. Because all lanes must show the same counters on the same cycle, the checker also shows that the lanes were deskewed correctly.

Four error classes are kept, each with a sticky flag and a saturating counter: tag, order, skew and burst. A counter of received words and a pass output let the traffic source confirm that the run was complete and clean. The sequence references for order and burst are taken from lane 0. The skew check ties every other lane to lane 0 through the chain of adjacent pairs.

Top module: `lane_sample_checker`

## Requirements
- R1: On a valid cycle, if the tag field (bits 63..59) of any lane's word differs from that lane's index (lane i occupies in_data bits 64*i+63..64*i), the tag class (err_flags bit 0) records an error.
- R2: On a checked valid cycle, if lane 0's word count (bits 31..0, unsigned) is not strictly greater than the word count of the previous valid cycle, the order class (err_flags bit 1) records an error.
- R3: On a valid cycle, if any two adjacent lanes differ in word count or burst count (bits 58..0), the skew class (err_flags bit 2) records an error.
- R4: On a checked valid cycle, the burst class (err_flags bit 3) records an error in two cases. With in_sob high, lane 0's burst count (bits 58..32) must be strictly greater than the previous valid burst count. With in_sob low, it must be equal to it.
- R5: Cycles with in_valid low are not checked, whatever in_data holds, and they leave all reference values, flags and counters unchanged. The references are taken from every valid word, including words that raised an error.
- R6: The first valid word after reset or clear only seeds the references and raises no order or burst error. Tag and skew checks still apply to it.
- R7: Each error flag stays set until clear or reset.
- R8: Each class counter adds exactly one per valid cycle in which that class has an error. Once it reaches all ones, it holds there.
- R9: rx_words adds one on every valid cycle that is not a clear cycle.
- R10: When clr is high at a clock edge, all flags, counters, rx_words and the seeded state go to zero. A valid word in that same cycle is neither checked, counted nor used as a reference.
- R11: pass is high exactly when rx_words equals expect_total and no error flag is set. It follows the registered state with no extra delay.
- R12: After reset, all flags and counters and rx_words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all results |
| in_valid | input | 1 | Sample words on in_data are valid |
| in_sob | input | 1 | This valid cycle starts a new burst |
| in_data | input | LANES*64 | One sample word per lane, lane 0 in the low bits |
| expect_total | input | WCNT_W | Word total that a complete run should reach |
| err_flags | output | 4 | Sticky flags: bit0 tag, bit1 order, bit2 skew, bit3 burst |
| tag_errs | output | ERR_CNT_W | Saturating count of tag-error cycles |
| order_errs | output | ERR_CNT_W | Saturating count of order-error cycles |
| skew_errs | output | ERR_CNT_W | Saturating count of skew-error cycles |
| burst_errs | output | ERR_CNT_W | Saturating count of burst-error cycles |
| rx_words | output | WCNT_W | Valid cycles received since reset or clear |
| pass | output | 1 | Complete and error-free run |

## Verification
The hardest states to reach are the ones that depend on history. These are a seed word whose counters lie below the values from before a clear, and a clear that lands on the same cycle as a valid word. A port-level driver reaches both on purpose. It clears in the middle of a stream, then restarts with smaller counters, and it pulses clr together with in_valid. It then checks that no order error appears and that the word count stays at zero. Counter saturation needs many error cycles. The bench therefore narrows the error counters through their parameter and drives a long run of bad-tag words.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int SAMPLE_W  = 64;
  localparam int TAG_LSB   = 59;
  localparam int TAG_W     = 5;
  localparam int BURST_LSB = 32;
  localparam int BURST_W   = 27;
  localparam int COUNT_W   = 32;
  localparam int NUM_ERR   = 4;

  typedef enum int {E_TAG = 0, E_ORDER = 1, E_SKEW = 2, E_BURST = 3} err_e;

  function automatic logic [TAG_W-1:0] tag_of(input logic [SAMPLE_W-1:0] w);
    return w[TAG_LSB +: TAG_W];
  endfunction

  function automatic logic [BURST_W-1:0] burst_of(input logic [SAMPLE_W-1:0] w);
    return w[BURST_LSB +: BURST_W];
  endfunction

  function automatic logic [COUNT_W-1:0] count_of(input logic [SAMPLE_W-1:0] w);
    return w[COUNT_W-1:0];
  endfunction
endpackage

// File: rtl/lsc_lane_compare.sv
module lsc_lane_compare
  import lsc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*SAMPLE_W-1:0] data,
  output logic                      tag_bad,
  output logic                      skew_bad
);
  logic [LANES-1:0] tag_miss;
  logic [LANES-1:0] pair_miss;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [SAMPLE_W-1:0] w;
      assign w = data[i*SAMPLE_W +: SAMPLE_W];
      assign tag_miss[i] = (tag_of(w) != TAG_W'(i));
      if (i == 0) begin : g_first
        assign pair_miss[i] = 1'b0;
      end else begin : g_pair
        logic [SAMPLE_W-1:0] wp;
        assign wp = data[(i-1)*SAMPLE_W +: SAMPLE_W];
        assign pair_miss[i] = (count_of(w) != count_of(wp)) ||
                              (burst_of(w) != burst_of(wp));
      end
    end
  endgenerate

  assign tag_bad  = |tag_miss;
  assign skew_bad = |pair_miss;
endmodule

// File: rtl/lsc_seq_track.sv
module lsc_seq_track
  import lsc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               valid,
  input  logic               sob,
  input  logic [COUNT_W-1:0] cnt0,
  input  logic [BURST_W-1:0] burst0,
  output logic               order_bad,
  output logic               burst_bad
);
  logic               seeded;
  logic [COUNT_W-1:0] last_cnt;
  logic [BURST_W-1:0] last_burst;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seeded     <= 1'b0;
      last_cnt   <= '0;
      last_burst <= '0;
    end else if (valid) begin
      seeded     <= 1'b1;
      last_cnt   <= cnt0;
      last_burst <= burst0;
    end
  end

  always_comb begin
    order_bad = valid && seeded && !(cnt0 > last_cnt);
    if (sob) burst_bad = valid && seeded && !(burst0 > last_burst);
    else     burst_bad = valid && seeded && (burst0 != last_burst);
  end
endmodule

// File: rtl/lsc_err_accum.sv
module lsc_err_accum #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          hit,
  output logic          flag,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flag  <= 1'b0;
      count <= '0;
    end else if (hit) begin
      flag  <= 1'b1;
      if (count != CMAX) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/lane_sample_checker.sv
module lane_sample_checker
  import lsc_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ERR_CNT_W = 32,
  parameter int WCNT_W    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      in_valid,
  input  logic                      in_sob,
  input  logic [LANES*SAMPLE_W-1:0] in_data,
  input  logic [WCNT_W-1:0]         expect_total,
  output logic [NUM_ERR-1:0]        err_flags,
  output logic [ERR_CNT_W-1:0]      tag_errs,
  output logic [ERR_CNT_W-1:0]      order_errs,
  output logic [ERR_CNT_W-1:0]      skew_errs,
  output logic [ERR_CNT_W-1:0]      burst_errs,
  output logic [WCNT_W-1:0]         rx_words,
  output logic                      pass
);
  logic                 live;
  logic                 tag_bad, skew_bad, order_bad, burst_bad;
  logic [NUM_ERR-1:0]   hits;
  logic [ERR_CNT_W-1:0] counts [NUM_ERR];

  assign live = in_valid && !clr;

  lsc_lane_compare #(.LANES(LANES)) u_cmp (
    .data     (in_data),
    .tag_bad  (tag_bad),
    .skew_bad (skew_bad)
  );

  lsc_seq_track u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .valid     (in_valid),
    .sob       (in_sob),
    .cnt0      (count_of(in_data[SAMPLE_W-1:0])),
    .burst0    (burst_of(in_data[SAMPLE_W-1:0])),
    .order_bad (order_bad),
    .burst_bad (burst_bad)
  );

  assign hits[E_TAG]   = live && tag_bad;
  assign hits[E_ORDER] = live && order_bad;
  assign hits[E_SKEW]  = live && skew_bad;
  assign hits[E_BURST] = live && burst_bad;

  generate
    for (genvar k = 0; k < NUM_ERR; k++) begin : g_err
      lsc_err_accum #(.CW(ERR_CNT_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .hit   (hits[k]),
        .flag  (err_flags[k]),
        .count (counts[k])
      );
    end
  endgenerate

  assign tag_errs   = counts[E_TAG];
  assign order_errs = counts[E_ORDER];
  assign skew_errs  = counts[E_SKEW];
  assign burst_errs = counts[E_BURST];

  always_ff @(posedge clk) begin
    if (rst || clr)    rx_words <= '0;
    else if (in_valid) rx_words <= rx_words + 1'b1;
  end

  assign pass = (rx_words == expect_total) && (err_flags == '0);
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker
  import lsc_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ERR_CNT_W = 32,
  parameter int WCNT_W    = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      clr,
  input logic                      in_valid,
  input logic [NUM_ERR-1:0]        err_flags,
  input logic [ERR_CNT_W-1:0]      tag_errs,
  input logic [WCNT_W-1:0]         rx_words
);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  p_word_step_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clr) |=> (rx_words == $past(rx_words) + 1'b1));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> ($stable(err_flags) && $stable(rx_words) && $stable(tag_errs)));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (rx_words == '0 && err_flags == '0 && tag_errs == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (tag_errs >= $past(tag_errs)));
endmodule

bind lane_sample_checker lsc_checker #(
  .LANES(LANES), .ERR_CNT_W(ERR_CNT_W), .WCNT_W(WCNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .in_valid  (in_valid),
  .err_flags (err_flags),
  .tag_errs  (tag_errs),
  .rx_words  (rx_words)
);

// File: tb/lane_sample_checker_test.sv
module lane_sample_checker_test;
  localparam int LANES = 4;
  localparam int ECW   = 4;
  localparam int WCW   = 32;
  localparam int DW    = LANES*64;

  logic clk = 0;
  logic rst = 1, clr = 0, in_valid = 0, in_sob = 0;
  logic [DW-1:0]  in_data = '0;
  logic [WCW-1:0] expect_total = '0;
  logic [3:0]     err_flags;
  logic [ECW-1:0] tag_errs, order_errs, skew_errs, burst_errs;
  logic [WCW-1:0] rx_words;
  logic           pass;

  always #5 clk = ~clk;

  lane_sample_checker #(.LANES(LANES), .ERR_CNT_W(ECW), .WCNT_W(WCW)) uut (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_sob(in_sob),
    .in_data(in_data), .expect_total(expect_total), .err_flags(err_flags),
    .tag_errs(tag_errs), .order_errs(order_errs), .skew_errs(skew_errs),
    .burst_errs(burst_errs), .rx_words(rx_words), .pass(pass)
  );

  int checks = 0, errors = 0;

  typedef struct {
    logic [3:0]     flags;
    logic [ECW-1:0] cnt [4];
    logic [WCW-1:0] words;
    logic           pass;
    string          req;
  } exp_t;
  exp_t q[$];

  // reference model state, written from the requirements
  bit             m_seeded;
  logic [31:0]    m_last_cnt;
  logic [26:0]    m_last_b;
  logic [3:0]     m_flags;
  logic [ECW-1:0] m_cnt [4];
  logic [WCW-1:0] m_words;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] word(input int tag, input int b, input int c);
    return {5'(tag), 27'(b), 32'(c)};
  endfunction

  function automatic logic [DW-1:0] lanes(input int b, input int c);
    logic [DW-1:0] d;
    for (int i = 0; i < LANES; i++) d[i*64 +: 64] = word(i, b, c);
    return d;
  endfunction

  task automatic model_reset();
    m_seeded = 0; m_last_cnt = 0; m_last_b = 0; m_flags = 0; m_words = 0;
    for (int k = 0; k < 4; k++) m_cnt[k] = 0;
  endtask

  // driver: called at a negedge, drives one cycle and queues the expected result
  task automatic beat(input bit v, input bit s, input bit c,
                      input logic [DW-1:0] d, input string req);
    exp_t e;
    logic [3:0] hit;
    in_valid = v; in_sob = s; clr = c; in_data = d;
    hit = 0;
    if (c) model_reset();
    else if (v) begin
      m_words++;
      for (int i = 0; i < LANES; i++)
        if (d[i*64+59 +: 5] != 5'(i)) hit[0] = 1;
      for (int i = 1; i < LANES; i++)
        if (d[i*64 +: 59] != d[(i-1)*64 +: 59]) hit[2] = 1;
      if (m_seeded) begin
        if (!(d[31:0] > m_last_cnt)) hit[1] = 1;
        if (s) begin if (!(d[58:32] > m_last_b)) hit[3] = 1; end
        else   begin if (d[58:32] != m_last_b)   hit[3] = 1; end
      end
      m_seeded = 1; m_last_cnt = d[31:0]; m_last_b = d[58:32];
      m_flags |= hit;
      for (int k = 0; k < 4; k++)
        if (hit[k] && m_cnt[k] != '1) m_cnt[k]++;
    end
    e.flags = m_flags;
    for (int k = 0; k < 4; k++) e.cnt[k] = m_cnt[k];
    e.words = m_words;
    e.pass  = (m_words == expect_total) && (m_flags == 0);
    e.req   = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: 2 ns after each rising edge, compare against the oldest queued item
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(err_flags == e.flags, e.req, "flags", 64'(err_flags), 64'(e.flags));
      chk(tag_errs == e.cnt[0] && order_errs == e.cnt[1] &&
          skew_errs == e.cnt[2] && burst_errs == e.cnt[3], "R8", "counters",
          {tag_errs, order_errs, skew_errs, burst_errs},
          {e.cnt[0], e.cnt[1], e.cnt[2], e.cnt[3]});
      chk(rx_words == e.words, "R9", "rx_words", 64'(rx_words), 64'(e.words));
      chk(pass == e.pass, "R11", "pass", 64'(pass), 64'(e.pass));
    end
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(err_flags == 0 && rx_words == 0 && tag_errs == 0 && order_errs == 0 &&
        skew_errs == 0 && burst_errs == 0, "R12", "reset state",
        {err_flags, rx_words}, 0);
    rst = 0;
    expect_total = 6;

    // R6: seed, then a clean stream with a new burst
    beat(1, 1, 0, lanes(1, 10), "R6");
    beat(1, 0, 0, lanes(1, 11), "R2");
    beat(1, 0, 0, lanes(1, 12), "R2");
    beat(1, 1, 0, lanes(2, 13), "R4");
    beat(1, 0, 0, lanes(2, 14), "R4");
    // R5: invalid cycle carrying bad data is ignored
    beat(0, 1, 0, {DW{1'b1}}, "R5");
    beat(1, 0, 0, lanes(2, 15), "R11");
    beat(0, 0, 0, '0, "R11");

    // R1: wrong tag on lane 2
    d = lanes(2, 16); d[2*64 +: 64] = word(7, 2, 16);
    beat(1, 0, 0, d, "R1");
    beat(1, 0, 0, lanes(2, 17), "R7");

    // R10: clear together with a valid word
    beat(1, 0, 1, lanes(2, 18), "R10");
    beat(0, 0, 0, '0, "R10");
    // R6: seed after clear with smaller counters, then a repeat count
    beat(1, 0, 0, lanes(9, 5), "R6");
    beat(1, 0, 0, lanes(9, 5), "R2");
    beat(1, 0, 0, lanes(9, 4), "R2");

    // R3: lane 3 count off by one
    beat(0, 0, 1, '0, "R10");
    beat(1, 1, 0, lanes(1, 1), "R3");
    d = lanes(1, 2); d[3*64 +: 64] = word(3, 1, 3);
    beat(1, 0, 0, d, "R3");
    d = lanes(1, 3); d[1*64 +: 64] = word(1, 2, 3);
    beat(1, 0, 0, d, "R3");

    // R4: start without a burst increase, then a change without a start
    beat(0, 0, 1, '0, "R10");
    beat(1, 0, 0, lanes(3, 1), "R4");
    beat(1, 1, 0, lanes(3, 2), "R4");
    beat(1, 0, 0, lanes(4, 3), "R4");
    // R7: flags stay set through clean words and idle cycles
    beat(1, 0, 0, lanes(4, 4), "R7");
    beat(0, 0, 0, '0, "R7");
    beat(1, 0, 0, lanes(4, 5), "R7");

    // R8: saturation of the narrowed tag counter
    beat(0, 0, 1, '0, "R10");
    for (int n = 0; n < 20; n++) begin
      d = lanes(1, n + 1); d[63:59] = 5'd9;
      beat(1, 0, 0, d, "R8");
    end

    // R11: pass with an expected total of zero after clear
    expect_total = 0;
    beat(0, 0, 1, '0, "R11");
    beat(0, 0, 0, '0, "R11");

    repeat (3) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule